// File: doc/BRIEF.md
# EEPROM Write-Protect and Block-Lock Guard

This block sits between the command decoder of a two-wire serial EEPROM slave and its memory array. Every nonvolatile byte write that the decoder requests passes through it, and it either forwards the byte to the array or drops it. It holds a protection register that is mapped at the top byte address, FFFFh. This register has three parts: a write-enable latch, a three-bit lock code that protects a range of the array starting at address 0000h, and a hardware-protect enable.

When the hardware-protect enable is set, the write-protect pin decides whether the protection settings are frozen. The pin is sampled once at the start of each bus transaction. The decoder presents one byte per request cycle. A page write is therefore judged byte by byte, and only the locked bytes of a page are dropped.

Top module: `eeprom_wp_guard`

## Requirements
- R1: After reset, `protReg` reads 00h and `arrayWrStrobe` is low.
- R2: A write to address FFFFh always loads the write-enable latch from data bit 1, whatever the other state is.
- R3: While the write-enable latch is clear, no array write is permitted and register bits 7:2 keep their value.
- R4: The `protReg` layout is as follows: bit 1 is the write-enable latch, bits 4:2 are the lock code, and bit 7 is the hardware-protect enable. Bits 0, 5 and 6 always read 0.
- R5: Lock code 0 protects nothing. Codes 1 to 7 protect, in this order, the addresses below 64, 128, 256, 512, one quarter of the array, one half of the array, and the whole array. Writes below the limit are dropped.
- R6: In back-to-back writes within one page, each byte is judged on its own. Unlocked bytes produce strobes and locked bytes do not.
- R7: If the pin was high at the last transaction start and bit 7 is set, a register write cannot change bits 7:2.
- R8: If the pin was low at the last transaction start, bit 7 does not stop changes to bits 7:2.
- R9: The pin is captured only on a `txnStart` pulse. Changes between pulses have no effect.
- R10: A permitted write raises `arrayWrStrobe` for one cycle on the clock edge that follows the request, carrying the request's address and data. Addresses from 8000h to FFFEh are never permitted.
- R11: A rejected write changes neither the array port nor `protReg`, apart from the write-enable latch loaded under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txnStart | input | 1 | One-cycle pulse at a bus start condition; captures the pin |
| wpPin | input | 1 | Write-protect pin |
| wrReq | input | 1 | Write request for one byte |
| wrAddr | input | 16 | Byte address of the request |
| wrData | input | 8 | Byte data of the request |
| arrayWrStrobe | output | 1 | One-cycle permit for the array |
| arrayWrAddr | output | 15 | Array address with the permit |
| arrayWrData | output | 8 | Array data with the permit |
| protReg | output | 8 | Protection register readback |

## Verification
The hardest case to reach is a pin change in the middle of a transaction. Reaching it needs several steps in order: the write-enable latch must be set, the hardware-protect bit must be programmed while the pin is still captured low or not yet active, and a start must capture the pin high. The pin is then driven low without a new start, and a register write is attempted. The stimulus follows exactly this order. It then issues a fresh start with the pin low, to show that the freeze lifts only at a transaction start. A behavioural model in the bench predicts the outputs and compares them with the design on every clock.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;
  localparam int WEL_BIT  = 1;
  localparam int LOCK_LSB = 2;
  localparam int LOCK_W   = 3;
  localparam int HWP_BIT  = 7;

  typedef struct packed {
    logic arrayWr;  // forward the byte to the array
    logic welWr;    // load the write-enable latch
    logic protWr;   // load lock code and hardware-protect bit
  } wp_strobe_t;
endpackage

// File: rtl/eeprom_wp_datapath.sv
module eeprom_wp_datapath
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 32768,
  parameter int PAGE_BYTES  = 64,
  parameter int DATA_W      = 8,
  localparam int ARRAY_AW   = $clog2(ARRAY_BYTES),
  localparam int LIM_W      = ADDR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txnStart,
  input  logic                wpPin,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  wp_strobe_t          strobes,
  output logic                isRegAddr,
  output logic                inArray,
  output logic                lockHit,
  output logic                welSet,
  output logic                hwFrozen,
  output logic                wpHeld,
  output logic                arrayWrStrobe,
  output logic [ARRAY_AW-1:0] arrayWrAddr,
  output logic [DATA_W-1:0]   arrayWrData,
  output logic [DATA_W-1:0]   protReg
);
  localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};
  localparam int NUM_CODES = 1 << LOCK_W;

  logic              welQ;
  logic [LOCK_W-1:0] lockQ;
  logic              hwpQ;
  logic [LIM_W-1:0]  limTab [NUM_CODES];

  // One upper limit per lock code; every range starts at address 0.
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_lim
    if (i == 0) begin : g_none
      assign limTab[i] = '0;
    end else if (i <= 4) begin : g_pages
      assign limTab[i] = LIM_W'(PAGE_BYTES << (i - 1));
    end else if (i == 5) begin : g_quarter
      assign limTab[i] = LIM_W'(ARRAY_BYTES / 4);
    end else if (i == 6) begin : g_half
      assign limTab[i] = LIM_W'(ARRAY_BYTES / 2);
    end else begin : g_all
      assign limTab[i] = LIM_W'(ARRAY_BYTES);
    end
  end

  always_comb begin
    isRegAddr = (wrAddr == REG_ADDR);
    inArray   = ({1'b0, wrAddr} < LIM_W'(ARRAY_BYTES));
    lockHit   = ({1'b0, wrAddr} < limTab[lockQ]);
    welSet    = welQ;
    hwFrozen  = wpHeld && hwpQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      welQ          <= 1'b0;
      lockQ         <= '0;
      hwpQ          <= 1'b0;
      wpHeld        <= 1'b0;
      arrayWrStrobe <= 1'b0;
      arrayWrAddr   <= '0;
      arrayWrData   <= '0;
    end else begin
      if (txnStart) wpHeld <= wpPin;
      if (strobes.welWr) welQ <= wrData[WEL_BIT];
      if (strobes.protWr) begin
        lockQ <= wrData[LOCK_LSB +: LOCK_W];
        hwpQ  <= wrData[HWP_BIT];
      end
      arrayWrStrobe <= strobes.arrayWr;
      if (strobes.arrayWr) begin
        arrayWrAddr <= wrAddr[ARRAY_AW-1:0];
        arrayWrData <= wrData;
      end
    end
  end

  always_comb begin
    protReg = '0;
    protReg[WEL_BIT]               = welQ;
    protReg[LOCK_LSB +: LOCK_W]    = lockQ;
    protReg[HWP_BIT]               = hwpQ;
  end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eeprom_wp_pkg::*;
(
  input  logic       wrReq,
  input  logic       isRegAddr,
  input  logic       inArray,
  input  logic       lockHit,
  input  logic       welSet,
  input  logic       hwFrozen,
  output wp_strobe_t strobes
);
  always_comb begin
    strobes         = '0;
    strobes.welWr   = wrReq && isRegAddr;
    strobes.protWr  = wrReq && isRegAddr && welSet && !hwFrozen;
    strobes.arrayWr = wrReq && !isRegAddr && inArray && !lockHit && welSet;
  end
endmodule

// File: rtl/eeprom_wp_guard.sv
module eeprom_wp_guard
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 32768,
  parameter int PAGE_BYTES  = 64,
  parameter int DATA_W      = 8,
  localparam int ARRAY_AW   = $clog2(ARRAY_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txnStart,
  input  logic                wpPin,
  input  logic                wrReq,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic                arrayWrStrobe,
  output logic [ARRAY_AW-1:0] arrayWrAddr,
  output logic [DATA_W-1:0]   arrayWrData,
  output logic [DATA_W-1:0]   protReg
);
  wp_strobe_t strobes;
  logic isRegAddr, inArray, lockHit, welSet, hwFrozen, wpHeld;

  eeprom_wp_ctrl u_ctrl (
    .wrReq(wrReq), .isRegAddr(isRegAddr), .inArray(inArray),
    .lockHit(lockHit), .welSet(welSet), .hwFrozen(hwFrozen),
    .strobes(strobes)
  );

  eeprom_wp_datapath #(
    .ADDR_W(ADDR_W), .ARRAY_BYTES(ARRAY_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .txnStart(txnStart), .wpPin(wpPin),
    .wrAddr(wrAddr), .wrData(wrData), .strobes(strobes),
    .isRegAddr(isRegAddr), .inArray(inArray), .lockHit(lockHit),
    .welSet(welSet), .hwFrozen(hwFrozen), .wpHeld(wpHeld),
    .arrayWrStrobe(arrayWrStrobe), .arrayWrAddr(arrayWrAddr),
    .arrayWrData(arrayWrData), .protReg(protReg)
  );
endmodule

// File: rtl/eeprom_wp_guard_chk.sv
module eeprom_wp_guard_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wpHeld,
  input logic              arrayWrStrobe,
  input logic [DATA_W-1:0] protReg
);
  // R4: unused bits stay at zero
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (protReg[0] == 1'b0) && (protReg[6:5] == 2'b00));

  // R3: a strobe needs the latch set when the request was seen
  assert_strobe_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arrayWrStrobe |-> ($past(wrReq) && $past(protReg[1])));

  // R10: nothing above the array is forwarded
  assert_no_high_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arrayWrStrobe |-> !$past(wrAddr[ADDR_W-1]));

  // R5: whole-array code blocks every byte
  assert_full_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arrayWrStrobe |-> ($past(protReg[4:2]) != 3'b111));

  // R7: frozen register keeps bits 7:2
  assert_hw_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrReq && (wrAddr == {ADDR_W{1'b1}}) && wpHeld && protReg[7])
      |=> $stable(protReg[7:2]));

  // R11: without a request the register does not move
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wrReq |=> $stable(protReg));
endmodule

bind eeprom_wp_guard eeprom_wp_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrReq(wrReq), .wrAddr(wrAddr), .wpHeld(wpHeld),
  .arrayWrStrobe(arrayWrStrobe), .protReg(protReg)
);

// File: tb/eeprom_wp_guard_tb.sv
module eeprom_wp_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txnStart = 1'b0;
  logic        wpPin = 1'b0;
  logic        wrReq = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        arrayWrStrobe;
  logic [14:0] arrayWrAddr;
  logic [7:0]  arrayWrData;
  logic [7:0]  protReg;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // reference model state
  bit         mWel, mWpen, mWpHeld;
  int         mLock;
  bit         eStrobe;
  int         eAddr, eData;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wp_guard u_dut (
    .clk(clk), .rst_n(rst_n), .txnStart(txnStart), .wpPin(wpPin),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .arrayWrStrobe(arrayWrStrobe), .arrayWrAddr(arrayWrAddr),
    .arrayWrData(arrayWrData), .protReg(protReg)
  );

  function automatic int lockLimit(int code);
    case (code)
      0: return 0;
      1: return 64;
      2: return 128;
      3: return 256;
      4: return 512;
      5: return 8192;
      6: return 16384;
      default: return 32768;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mWel <= 0; mWpen <= 0; mWpHeld <= 0; mLock <= 0;
      eStrobe <= 0; eAddr <= 0; eData <= 0;
    end else begin
      eStrobe <= 0;
      if (wrReq) begin
        if (wrAddr == 16'hFFFF) begin
          if (mWel && !(mWpHeld && mWpen)) begin
            mLock <= int'(wrData[4:2]);
            mWpen <= wrData[7];
          end
          mWel <= wrData[1];
        end else if (mWel && int'(wrAddr) < 32768 && int'(wrAddr) >= lockLimit(mLock)) begin
          eStrobe <= 1; eAddr <= int'(wrAddr); eData <= int'(wrData);
        end
      end
      if (txnStart) mWpHeld <= wpPin;
    end
  end

  always @(negedge clk) begin
    int expReg;
    cycles++;
    if (!done) begin
      expReg = (mWpen ? 128 : 0) + (mLock << 2) + (mWel ? 2 : 0);
      checks++;
      if (arrayWrStrobe !== eStrobe) begin
        fails++;
        $display("FAIL %s strobe actual=%0b expected=%0b t=%0t", curReq, arrayWrStrobe, eStrobe, $time);
      end else if (eStrobe && (int'(arrayWrAddr) != eAddr || int'(arrayWrData) != eData)) begin
        fails++;
        $display("FAIL %s addr/data actual=%h/%h expected=%h/%h", curReq, arrayWrAddr, arrayWrData, eAddr, eData);
      end else if (int'(protReg) != expReg) begin
        fails++;
        $display("FAIL %s protReg actual=%h expected=%h", curReq, protReg, expReg);
      end
    end
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrReq = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrReq = 0;
  endtask

  task automatic start(input logic wp);
    @(negedge clk);
    txnStart = 1; wpPin = wp;
    @(negedge clk);
    txnStart = 0;
  endtask

  initial begin
    curReq = "R1";
    idle(3);
    rst_n = 1;
    idle(3);

    curReq = "R3";
    wr(16'h0100, 8'hA5);
    wr(16'h7FFF, 8'h11);
    curReq = "R2";
    wr(16'hFFFF, 8'hFE);          // WEL clear: only latch loads
    idle(2);
    curReq = "R4";
    wr(16'hFFFF, 8'hFF);          // full layout readback 9Eh
    idle(2);
    curReq = "R8";
    wr(16'hFFFF, 8'h02);          // WPEN set but pin held low
    idle(2);

    curReq = "R5";
    for (int c = 0; c < 8; c++) begin
      wr(16'hFFFF, 8'((c << 2) | 2));
      wr(16'(lockLimit(c) == 0 ? 0 : lockLimit(c) - 1), 8'(c));
      if (lockLimit(c) < 32768) wr(16'(lockLimit(c)), 8'(c + 16));
      wr(16'h0000, 8'h5A);
      wr(16'h7FFF, 8'hC3);
    end

    curReq = "R6";
    wr(16'hFFFF, 8'h06);          // first page locked
    @(negedge clk);
    for (int b = 16'h3C; b < 16'h44; b++) begin
      wrReq = 1; wrAddr = 16'(b); wrData = 8'(b ^ 8'h33);
      @(negedge clk);
    end
    wrReq = 0;
    idle(2);

    curReq = "R10";
    wr(16'hFFFF, 8'h02);
    wr(16'h8000, 8'h77);
    wr(16'hFFFE, 8'h78);
    wr(16'h1234, 8'h9C);

    curReq = "R7";
    start(1'b1);
    wr(16'hFFFF, 8'h8E);          // WPEN was 0: allowed
    wr(16'hFFFF, 8'h02);          // now frozen
    wr(16'h0010, 8'h01);
    wr(16'h0200, 8'h02);

    curReq = "R9";
    wpPin = 0;
    idle(2);
    wr(16'hFFFF, 8'h02);          // still frozen, no new start
    start(1'b0);
    curReq = "R8";
    wr(16'hFFFF, 8'h02);
    idle(2);

    curReq = "R11";
    wr(16'hFFFF, 8'h00);          // clear latch
    wr(16'h0400, 8'h44);
    wr(16'hFFFF, 8'hBC);          // bits must not load
    wr(16'h0401, 8'h45);
    idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule